// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block is a timer peripheral reached through a small word-wide register port. An 8-bit divider slows the incoming clock and steps a 24-bit up counter. When the counter reaches a programmed compare value, a sticky flag is raised, and an interrupt line follows that flag when interrupts are enabled. Software chooses between stopping after one match, rewinding at every match, or running freely with a wrap at 2^24. It can also make the counter step on rising edges of an external event pin instead of on the divided clock.

Software can clear the divider, the counter and the run bit with one control write. A debug-halt input freezes counting unless a control bit tells the timer to ignore it. The counter is visible through a data register that follows the counter only while its load bit is set. Writing a new compare value restarts counting in every mode except free-running.

The register port uses a valid/ready handshake. `bus_ready` is tied high, so every request completes in the cycle it is presented and there is never back-pressure. A write takes effect at the clock edge where `bus_valid && bus_write` is seen. Read data is combinational and is valid in the same cycle as `bus_valid && !bus_write`. In every other cycle it reads as zero.

Top module: `cmtimer`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `bus_ready` is 1. The register offsets are control 0x0, compare 0x4, status 0x8 and data 0xC.
- R2: With event mode off, the counter steps once every (P+1) cycles while running, where P is control bits [7:0]. The first step comes P+1 edges after the enabling write. While load is on, the data register (bits [23:0]) copies the counter one cycle late.
- R3: When a step makes the counter equal to the compare value (compare bits [23:0]), status bit 0 is set at that edge. `irq` equals status bit 0 AND control bit 29.
- R4: Writing 1 to status bit 0 clears it. Writing 0 to it leaves it unchanged.
- R5: Control bits [28:27] select the mode. In mode 00, a match rewinds the counter to 0 and clears run bit 30. In mode 01, a match rewinds the counter to 0. Mode 10 behaves as 01. In mode 11, the counter keeps going past the match and wraps at 2^24.
- R6: A compare write in modes 00, 01 and 10 clears the counter and the divider at the same edge. In mode 11, a compare write leaves the counter undisturbed.
- R7: A control write with bit 26 set clears the divider and the counter. The run bit ends at 0 if the timer was active. Bit 26 always reads 0.
- R8: While control bit 16 is 0, the data register holds its value.
- R9: While `dbg_halt` is 1 and control bit 31 is 0, the counter holds its value. With bit 31 set to 1, counting continues through a halt.
- R10: With control bit 24 set to 1, the counter steps once for each rising edge of `evt_in`, after a two-stage synchronizer. The divider is unused in this mode.
- R11: Control bit 25 reads 1 exactly when the run bit is 1 and the counter is not halted. Writes to bit 25 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as a read request |
| evt_in | input | 1 | External event pin (asynchronous) |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, counter steps and flag sets all land on the clock edge that carries them. The data register lags the counter by exactly one more edge. `irq` and read data follow their registers combinationally. The bench drives each request just after a falling edge and counts the rising edges from the enabling write. For a counter value reached at edge E+n, it expects the data register to show that value only after edge E+n+1. Every read samples 1 ns after a falling edge, so it sees settled values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_FREE   = 2'b11
  } tmr_mode_e;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMP  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_DATA = 4'hC;

  localparam int B_LOAD    = 16;
  localparam int B_EVT     = 24;
  localparam int B_ACT     = 25;
  localparam int B_SRST    = 26;
  localparam int B_MODE_LO = 27;
  localparam int B_IE      = 29;
  localparam int B_EN      = 30;
  localparam int B_DBG     = 31;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic            evt_mode,
  input  logic [PS_W-1:0] prescale,
  input  logic            evt_in,
  output logic            tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   evt_prev;
  logic [PS_W-1:0]        pcnt;
  logic                   ps_hit;
  logic                   evt_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      evt_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], evt_in};
      evt_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign evt_rise = sync_q[SYNC_STAGES-1] & ~evt_prev;
  assign ps_hit   = (pcnt >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (clr)              pcnt <= '0;
    else if (run && !evt_mode) pcnt <= ps_hit ? '0 : pcnt + 1'b1;
  end

  assign tick = run & (evt_mode ? evt_rise : ps_hit);

  // R2: with a nonzero divider, two steps are never back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !evt_mode) |=> (prescale == '0 || !tick || evt_mode));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;
  assign match   = tick & ~clr & (cnt_inc == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clr)                       cnt <= '0;
    else if (match && mode != MODE_FREE) cnt <= '0;
    else if (tick)                      cnt <= cnt_inc;
  end

  // R5: free-running mode carries on past the compare value
  p_free_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == MODE_FREE) |=> (cnt == $past(cmp)));

  // R2: without a step or clear, the counter does not move
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/cmtimer.sv
module cmtimer import tmr_pkg::*; #(
  parameter int PS_W        = 8,
  parameter int CNT_W       = 24,
  parameter int AW          = 4,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          evt_in,
  input  logic          dbg_halt,
  output logic          irq
);
  logic [PS_W-1:0]  ps_q;
  logic             load_q, evt_q, ie_q, en_q, dbg_q, flag_q;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] cmp_q, data_q, cnt;
  logic             wr_ctrl, wr_cmp, wr_stat, rd_req;
  logic             active, restart, tick, match;
  logic [DW-1:0]    rd_ctrl;
  logic             unused_act_bit;

  assign bus_ready = 1'b1;
  assign wr_ctrl = bus_valid & bus_write & (bus_addr == OFS_CTRL);
  assign wr_cmp  = bus_valid & bus_write & (bus_addr == OFS_CMP);
  assign wr_stat = bus_valid & bus_write & (bus_addr == OFS_STAT);
  assign rd_req  = bus_valid & ~bus_write;
  assign unused_act_bit = bus_wdata[B_ACT];

  assign active  = en_q & ~(dbg_halt & ~dbg_q);
  assign restart = (wr_ctrl & bus_wdata[B_SRST]) |
                   (wr_cmp & (mode_q != MODE_FREE));

  tmr_tick_gen #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active), .clr(restart),
    .evt_mode(evt_q), .prescale(ps_q), .evt_in(evt_in), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(restart),
    .mode(mode_q), .cmp(cmp_q), .cnt(cnt), .match(match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      load_q <= 1'b0;
      evt_q  <= 1'b0;
      mode_q <= MODE_ONCE;
      ie_q   <= 1'b0;
      dbg_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      ps_q   <= bus_wdata[PS_W-1:0];
      load_q <= bus_wdata[B_LOAD];
      evt_q  <= bus_wdata[B_EVT];
      mode_q <= tmr_mode_e'(bus_wdata[B_MODE_LO +: 2]);
      ie_q   <= bus_wdata[B_IE];
      dbg_q  <= bus_wdata[B_DBG];
      en_q   <= bus_wdata[B_EN] & ~(bus_wdata[B_SRST] & active);
    end else if (match && mode_q == MODE_ONCE) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag_q <= 1'b0;
    else if (match)                 flag_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_q) data_q <= cnt;
  end

  assign irq = flag_q & ie_q;

  always_comb begin
    rd_ctrl                    = '0;
    rd_ctrl[PS_W-1:0]          = ps_q;
    rd_ctrl[B_LOAD]            = load_q;
    rd_ctrl[B_EVT]             = evt_q;
    rd_ctrl[B_ACT]             = active;
    rd_ctrl[B_MODE_LO +: 2]    = mode_q;
    rd_ctrl[B_IE]              = ie_q;
    rd_ctrl[B_EN]              = en_q;
    rd_ctrl[B_DBG]             = dbg_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = rd_ctrl;
        OFS_CMP:  bus_rdata[CNT_W-1:0] = cmp_q;
        OFS_STAT: bus_rdata[0] = flag_q;
        OFS_DATA: bus_rdata[CNT_W-1:0] = data_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4: the flag survives every cycle without a write-one clear
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && bus_wdata[0])) |=> flag_q);

  // R5: a single-shot match stops the timer
  p_once_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode_q == MODE_ONCE && !wr_ctrl) |=> !en_q);

  // R6: a compare write outside free-running mode restarts from zero
  p_cmp_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && mode_q != MODE_FREE) |=> (cnt == '0));

  // R7: the software reset bit zeroes the counter and stops an active timer
  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_SRST] && active) |=> (cnt == '0 && !en_q));

  // R8: with load off the data register keeps its value
  p_load_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |=> $stable(data_q));

  // R9: an honoured debug halt freezes the counter
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !dbg_q && !(bus_valid && bus_write)) |=> $stable(cnt));
endmodule

// File: tb/tb_cmtimer.sv
module tb_cmtimer;
  import tmr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int VP [NV] = '{0, 0, 3, 3, 0, 0, 1, 2};
  localparam int VM [NV] = '{1, 1, 1, 1, 0, 3, 2, 3};
  localparam int VC [NV] = '{10, 10, 5, 5, 4, 4, 3, 100};
  localparam int VN [NV] = '{5, 13, 14, 22, 10, 10, 9, 31};
  localparam int VD [NV] = '{4, 2, 3, 0, 0, 9, 1, 10};
  localparam int VF [NV] = '{0, 1, 0, 1, 1, 1, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        evt_in = 1'b0, dbg_halt = 1'b0, irq;
  int          total = 0, bad = 0;
  logic [31:0] v, d1, d2;

  cmtimer dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_in(evt_in), .dbg_halt(dbg_halt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input int ps, input bit load, input bit evt,
      input int mode, input bit ie, input bit en, input bit dbg, input bit srst);
    logic [31:0] w;
    w = '0;
    w[7:0] = ps[7:0];
    w[16] = load; w[24] = evt; w[28:27] = mode[1:0];
    w[29] = ie; w[30] = en; w[31] = dbg; w[26] = srst;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] r);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    r = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input int ps, input int mode, input int cmpv);
    wr(OFS_CTRL, mk(0, 1, 0, 1, 0, 0, 0, 1));
    wr(OFS_STAT, 32'h1);
    wr(OFS_CMP, cmpv);
    wr(OFS_CTRL, mk(ps, 1, 0, mode, 0, 1, 0, 0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    rd(OFS_CTRL, v); chk("R1 ctrl", v, 0);
    rd(OFS_CMP, v);  chk("R1 cmp", v, 0);
    rd(OFS_STAT, v); chk("R1 stat", v, 0);
    rd(OFS_DATA, v); chk("R1 data", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ready", {31'b0, bus_ready}, 1);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R5: vector table over divider, mode and compare value
    for (int i = 0; i < NV; i++) begin
      start(VP[i], VM[i], VC[i]);
      idle(VN[i]);
      rd(OFS_DATA, v); chk($sformatf("R2/R5 row%0d data", i), v, VD[i]);
      rd(OFS_STAT, v); chk($sformatf("R3 row%0d flag", i), v, VF[i]);
    end

    // R3 R4: interrupt gating and write-one clear
    start(0, 1, 3);
    idle(10);
    rd(OFS_STAT, v); chk("R3 flag set", v, 1);
    chk("R3 irq masked", {31'b0, irq}, 0);
    wr(OFS_CTRL, mk(0, 1, 0, 1, 1, 1, 0, 0));
    #1 chk("R3 irq enabled", {31'b0, irq}, 1);
    wr(OFS_CTRL, mk(0, 1, 0, 1, 1, 0, 0, 0));
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, v); chk("R4 write0 keeps", v, 1);
    wr(OFS_STAT, 32'h1);
    rd(OFS_STAT, v); chk("R4 write1 clears", v, 0);
    chk("R4 irq low", {31'b0, irq}, 0);

    // R7 R11: software reset bit and active status
    start(0, 1, 1000);
    idle(8);
    rd(OFS_CTRL, v); chk("R11 active", {31'b0, v[B_ACT]}, 1);
    wr(OFS_CTRL, mk(0, 1, 0, 1, 0, 1, 0, 1));
    rd(OFS_CTRL, v);
    chk("R7 en cleared", {31'b0, v[B_EN]}, 0);
    chk("R7 srst reads 0", {31'b0, v[B_SRST]}, 0);
    idle(2);
    rd(OFS_DATA, v); chk("R7 counter zero", v, 0);
    wr(OFS_CTRL, 32'h1 << B_ACT);
    rd(OFS_CTRL, v); chk("R11 status write ignored", v, 0);

    // R6: compare write restarts except in free-running mode
    start(0, 1, 1000);
    idle(20);
    wr(OFS_CMP, 1000);
    idle(5);
    rd(OFS_DATA, v); chk("R6 periodic restart", v, 4);
    start(0, 3, 1000);
    idle(20);
    wr(OFS_CMP, 1000);
    rd(OFS_DATA, v); chk("R6 free no restart", v, 20);

    // R8: data register holds while load is off
    start(0, 1, 1000);
    idle(10);
    wr(OFS_CTRL, mk(0, 0, 0, 1, 0, 1, 0, 0));
    rd(OFS_DATA, d1); chk("R8 snapshot", d1, 10);
    idle(10);
    rd(OFS_DATA, d2); chk("R8 hold", d2, d1);
    wr(OFS_CTRL, mk(0, 1, 0, 1, 0, 1, 0, 0));
    idle(3);
    rd(OFS_DATA, v); chk("R8 resume", v, 24);

    // R9 R11: debug halt and its override
    start(0, 1, 1000);
    idle(5);
    dbg_halt = 1'b1;
    idle(4);
    rd(OFS_DATA, d1); chk("R9 frozen value", d1, 5);
    rd(OFS_CTRL, v); chk("R11 halted inactive", {31'b0, v[B_ACT]}, 0);
    idle(6);
    rd(OFS_DATA, d2); chk("R9 still frozen", d2, d1);
    wr(OFS_CTRL, mk(0, 1, 0, 1, 0, 1, 1, 0));
    idle(2);
    rd(OFS_DATA, d1);
    idle(6);
    rd(OFS_DATA, d2); chk("R9 override counts", d2, d1 + 6);
    dbg_halt = 1'b0;

    // R10: event counting ignores the divider
    wr(OFS_CTRL, mk(0, 1, 0, 1, 0, 0, 0, 1));
    wr(OFS_CMP, 1000);
    wr(OFS_CTRL, mk(5, 1, 1, 1, 0, 1, 0, 0));
    for (int k = 0; k < 6; k++) begin
      evt_in = 1'b1; idle(2);
      evt_in = 1'b0; idle(2);
    end
    idle(6);
    rd(OFS_DATA, v); chk("R10 event count", v, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule